// File: doc/BRIEF.md
# DMA Channel Request Scheduler

This block decides which of 32 DMA channels the sequencer runs next. Software programs it through a small word-addressed register port. Per-event masks route hardware request pulses to channels. Each channel has a start bit, a 3-bit priority and three gating override bits. A request pulse on an event line leaves a pending flag on every channel that the event's mask selects.

Each cycle the block looks at the channels that are allowed to run. When no channel is granted, it grants the eligible channel with the highest priority. On equal priority the lowest channel number wins. The grant stays in force until the data engine signals completion. Completion raises the channel's interrupt flag. It also clears the channel's start bit unless a keep-running input is held. Channel 0 is meant to be the command channel, but the scheduling logic treats it like any other channel.

Register offsets: 0x000 sets start bits (write 1 to set), 0x004 clears start bits (write 1 to clear), and both read back the start bits. 0x008 holds the interrupt flags (write 1 to clear). 0x00C, 0x010 and 0x014 hold the event, host and coprocessor overrides. 0x018 reads the pending flags. 0x100 + 4·n holds channel n's priority. 0x200 + 4·e holds event e's channel mask. Bit n of every per-channel register refers to channel n.

Top module: `dma_chan_sched`

## Requirements
- R1: A write to 0x000 sets each start bit whose data bit is 1; data bits at 0 leave the corresponding start bits unchanged; reading 0x000 or 0x004 returns the start bits.
- R2: A write to 0x004 clears each start bit whose data bit is 1.
- R3: An event pulse sets the pending flag (read at 0x018) of every channel whose bit is set in that event's mask; channels outside the mask are not affected.
- R4: Channel n is eligible when all of the following hold: its start bit or host override is set; its pending flag or event override is set; its coprocessor override or `dsp_ready[n]` is set; and its priority is non-zero.
- R5: A channel with priority 0 is never granted, even when every other condition holds.
- R6: Among eligible channels the highest priority is granted; on equal priority the lowest channel number is granted.
- R7: A grant appears on the clock edge after the channel becomes eligible. At the same edge the granted channel's pending flag clears. `grant_vld` and `grant_ch` then hold until `done`, and `grant_vld` drops at the `done` edge.
- R8: `done` while a grant is active sets that channel's interrupt flag. It also clears that channel's start bit unless `keep_run` is 1.
- R9: Writing 1 to a bit of 0x008 clears that interrupt flag. A completion in the same cycle wins over the clear.
- R10: After reset all start, interrupt, pending, override, priority and mask state reads 0 and `grant_vld` is 0.
- R11: A priority register stores only its low 3 bits; the upper read bits are 0.
- R12: A mask register whose event index is not below the configured event count ignores writes and reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 12 | Byte address for read and write |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data for `addr` (combinational) |
| evt_req | input | NUM_EVT | Event request pulses |
| dsp_ready | input | NUM_CH | Per-channel coprocessor go signals |
| done | input | 1 | Completion of the granted channel |
| keep_run | input | 1 | Keep the start bit on completion |
| grant_vld | output | 1 | A channel is granted |
| grant_ch | output | 5 | Granted channel number |
| irq_status | output | NUM_CH | Per-channel interrupt flags |

## Verification
The hardest situations to reach from the ports depend on two things landing in the same cycle. One is a completion that coincides with a write-1-to-clear of the same interrupt flag. The other is several channels of equal priority becoming eligible at once. The bench reaches the tie by configuring the priorities and event overrides first and then setting all the start bits in one write. It reaches the collision by raising `done` in the same half-cycle as the clearing write. Gating by priority 0, by the coprocessor input and by the host override is reached by withholding one condition at a time. The bench then checks that no grant appears until that condition is supplied.

// File: rtl/dma_sched_pkg.sv
package dma_sched_pkg;

    localparam int ADDR_W = 12;
    localparam int DATA_W = 32;
    localparam int PRIO_W = 3;
    localparam int IDX_W  = 6;

    localparam logic [ADDR_W-1:0] OFS_START = 12'h000;
    localparam logic [ADDR_W-1:0] OFS_STOP  = 12'h004;
    localparam logic [ADDR_W-1:0] OFS_IRQ   = 12'h008;
    localparam logic [ADDR_W-1:0] OFS_EOVR  = 12'h00C;
    localparam logic [ADDR_W-1:0] OFS_HOVR  = 12'h010;
    localparam logic [ADDR_W-1:0] OFS_DOVR  = 12'h014;
    localparam logic [ADDR_W-1:0] OFS_PEND  = 12'h018;
    localparam logic [ADDR_W-1:0] OFS_PRIO  = 12'h100;
    localparam logic [ADDR_W-1:0] OFS_EMAP  = 12'h200;

    typedef enum logic [3:0] {
        SEL_NONE, SEL_START, SEL_STOP, SEL_IRQ, SEL_EOVR,
        SEL_HOVR, SEL_DOVR, SEL_PEND, SEL_PRIO, SEL_EMAP
    } sel_e;

    typedef struct packed {
        sel_e             sel;
        logic [IDX_W-1:0] idx;
    } dec_t;

    function automatic dec_t decode(input logic [ADDR_W-1:0] a);
        dec_t d;
        d.idx = a[7:2];
        d.sel = SEL_NONE;
        case (a[ADDR_W-1:8])
            4'h0: begin
                case (a[7:2])
                    6'd0: d.sel = SEL_START;
                    6'd1: d.sel = SEL_STOP;
                    6'd2: d.sel = SEL_IRQ;
                    6'd3: d.sel = SEL_EOVR;
                    6'd4: d.sel = SEL_HOVR;
                    6'd5: d.sel = SEL_DOVR;
                    6'd6: d.sel = SEL_PEND;
                    default: d.sel = SEL_NONE;
                endcase
            end
            4'h1:    d.sel = SEL_PRIO;
            4'h2:    d.sel = SEL_EMAP;
            default: d.sel = SEL_NONE;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/dma_sched_regs.sv
module dma_sched_regs
    import dma_sched_pkg::*;
#(
    parameter int NUM_CH  = 32,
    parameter int NUM_EVT = 48,
    parameter int CH_W    = $clog2(NUM_CH)
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            wr_en,
    input  logic [ADDR_W-1:0]               addr,
    input  logic [DATA_W-1:0]               wr_data,
    output logic [DATA_W-1:0]               rd_data,
    input  logic                            done_fire,
    input  logic [CH_W-1:0]                 done_ch,
    input  logic                            keep_run,
    input  logic [NUM_CH-1:0]               pend_vec,
    output logic [NUM_CH-1:0]               start_q,
    output logic [NUM_CH-1:0]               irq_q,
    output logic [NUM_CH-1:0]               eovr_q,
    output logic [NUM_CH-1:0]               hovr_q,
    output logic [NUM_CH-1:0]               dovr_q,
    output logic [NUM_CH-1:0][PRIO_W-1:0]   prio_q,
    output logic [NUM_EVT-1:0][NUM_CH-1:0]  emap_q
);
    localparam int EV_W = $clog2(NUM_EVT);

    dec_t              dec;
    logic [NUM_CH-1:0] wbits;
    logic [NUM_CH-1:0] done_mask;
    logic [NUM_CH-1:0] set_start, clr_start, clr_irq;

    assign dec       = decode(addr);
    assign wbits     = wr_data[NUM_CH-1:0];
    assign done_mask = done_fire ? (NUM_CH'(1) << done_ch) : '0;
    assign set_start = (wr_en && dec.sel == SEL_START) ? wbits : '0;
    assign clr_irq   = (wr_en && dec.sel == SEL_IRQ)   ? wbits : '0;
    assign clr_start = ((wr_en && dec.sel == SEL_STOP) ? wbits : '0)
                     | (keep_run ? '0 : done_mask);

    always_ff @(posedge clk) begin
        if (rst) begin
            start_q <= '0;
            irq_q   <= '0;
            eovr_q  <= '0;
            hovr_q  <= '0;
            dovr_q  <= '0;
        end else begin
            start_q <= (start_q & ~clr_start) | set_start;
            irq_q   <= (irq_q & ~clr_irq) | done_mask;
            if (wr_en && dec.sel == SEL_EOVR) eovr_q <= wbits;
            if (wr_en && dec.sel == SEL_HOVR) hovr_q <= wbits;
            if (wr_en && dec.sel == SEL_DOVR) dovr_q <= wbits;
        end
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_prio
        always_ff @(posedge clk) begin
            if (rst)
                prio_q[c] <= '0;
            else if (wr_en && dec.sel == SEL_PRIO && dec.idx == IDX_W'(c))
                prio_q[c] <= wr_data[PRIO_W-1:0];
        end
    end

    for (genvar e = 0; e < NUM_EVT; e++) begin : g_emap
        always_ff @(posedge clk) begin
            if (rst)
                emap_q[e] <= '0;
            else if (wr_en && dec.sel == SEL_EMAP && dec.idx == IDX_W'(e))
                emap_q[e] <= wbits;
        end
    end

    always_comb begin
        rd_data = '0;
        case (dec.sel)
            SEL_START, SEL_STOP: rd_data = DATA_W'(start_q);
            SEL_IRQ:             rd_data = DATA_W'(irq_q);
            SEL_EOVR:            rd_data = DATA_W'(eovr_q);
            SEL_HOVR:            rd_data = DATA_W'(hovr_q);
            SEL_DOVR:            rd_data = DATA_W'(dovr_q);
            SEL_PEND:            rd_data = DATA_W'(pend_vec);
            SEL_PRIO:
                if (int'(dec.idx) < NUM_CH)
                    rd_data = DATA_W'(prio_q[dec.idx[CH_W-1:0]]);
            SEL_EMAP:
                if (int'(dec.idx) < NUM_EVT)
                    rd_data = DATA_W'(emap_q[dec.idx[EV_W-1:0]]);
            default:             rd_data = '0;
        endcase
    end

endmodule

// File: rtl/dma_sched_evt.sv
module dma_sched_evt #(
    parameter int NUM_CH  = 32,
    parameter int NUM_EVT = 48,
    parameter int CH_W    = $clog2(NUM_CH)
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic [NUM_EVT-1:0]              evt_req,
    input  logic [NUM_EVT-1:0][NUM_CH-1:0]  emap_q,
    input  logic                            grant_fire,
    input  logic [CH_W-1:0]                 grant_sel,
    output logic [NUM_CH-1:0]               pend_q
);
    logic [NUM_CH-1:0] set_mask;
    logic [NUM_CH-1:0] clr_mask;

    always_comb begin
        set_mask = '0;
        for (int e = 0; e < NUM_EVT; e++)
            if (evt_req[e]) set_mask = set_mask | emap_q[e];
    end

    assign clr_mask = grant_fire ? (NUM_CH'(1) << grant_sel) : '0;

    always_ff @(posedge clk) begin
        if (rst) pend_q <= '0;
        else     pend_q <= (pend_q & ~clr_mask) | set_mask;
    end

endmodule

// File: rtl/dma_sched_pick.sv
module dma_sched_pick
    import dma_sched_pkg::*;
#(
    parameter int NUM_CH = 32,
    parameter int CH_W   = $clog2(NUM_CH)
) (
    input  logic [NUM_CH-1:0]             elig,
    input  logic [NUM_CH-1:0][PRIO_W-1:0] prio,
    output logic                          any,
    output logic [CH_W-1:0]               win_ch
);
    logic [PRIO_W-1:0] best_p;

    always_comb begin
        best_p = '0;
        win_ch = '0;
        any    = 1'b0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (elig[c] && prio[c] > best_p) begin
                best_p = prio[c];
                win_ch = CH_W'(c);
                any    = 1'b1;
            end
        end
    end

endmodule

// File: rtl/dma_chan_sched.sv
module dma_chan_sched
    import dma_sched_pkg::*;
#(
    parameter int NUM_CH  = 32,
    parameter int NUM_EVT = 48,
    parameter int CH_W    = $clog2(NUM_CH)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [DATA_W-1:0]  wr_data,
    output logic [DATA_W-1:0]  rd_data,
    input  logic [NUM_EVT-1:0] evt_req,
    input  logic [NUM_CH-1:0]  dsp_ready,
    input  logic               done,
    input  logic               keep_run,
    output logic               grant_vld,
    output logic [CH_W-1:0]    grant_ch,
    output logic [NUM_CH-1:0]  irq_status
);
    logic [NUM_CH-1:0]             start_q, irq_q, eovr_q, hovr_q, dovr_q;
    logic [NUM_CH-1:0][PRIO_W-1:0] prio_q;
    logic [NUM_EVT-1:0][NUM_CH-1:0] emap_q;
    logic [NUM_CH-1:0]             pend_q;
    logic [NUM_CH-1:0]             prio_nz;
    logic [NUM_CH-1:0]             elig;
    logic                          any_elig;
    logic [CH_W-1:0]               win_ch;
    logic                          grant_fire;
    logic                          done_fire;

    assign grant_fire = !grant_vld && any_elig;
    assign done_fire  = grant_vld && done;

    dma_sched_regs #(.NUM_CH(NUM_CH), .NUM_EVT(NUM_EVT), .CH_W(CH_W)) u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
        .rd_data(rd_data), .done_fire(done_fire), .done_ch(grant_ch),
        .keep_run(keep_run), .pend_vec(pend_q), .start_q(start_q),
        .irq_q(irq_q), .eovr_q(eovr_q), .hovr_q(hovr_q), .dovr_q(dovr_q),
        .prio_q(prio_q), .emap_q(emap_q)
    );

    dma_sched_evt #(.NUM_CH(NUM_CH), .NUM_EVT(NUM_EVT), .CH_W(CH_W)) u_evt (
        .clk(clk), .rst(rst), .evt_req(evt_req), .emap_q(emap_q),
        .grant_fire(grant_fire), .grant_sel(win_ch), .pend_q(pend_q)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_nz
        assign prio_nz[c] = |prio_q[c];
    end

    assign elig = (start_q | hovr_q) & (pend_q | eovr_q)
                & (dovr_q | dsp_ready) & prio_nz;

    dma_sched_pick #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_pick (
        .elig(elig), .prio(prio_q), .any(any_elig), .win_ch(win_ch)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            grant_vld <= 1'b0;
            grant_ch  <= '0;
        end else if (done_fire) begin
            grant_vld <= 1'b0;
        end else if (grant_fire) begin
            grant_vld <= 1'b1;
            grant_ch  <= win_ch;
        end
    end

    assign irq_status = irq_q;

endmodule

// File: rtl/dma_sched_chk.sv
module dma_sched_chk
    import dma_sched_pkg::*;
#(
    parameter int NUM_CH = 32,
    parameter int CH_W   = $clog2(NUM_CH)
) (
    input logic                          clk,
    input logic                          rst,
    input logic                          wr_en,
    input logic [ADDR_W-1:0]             addr,
    input logic [DATA_W-1:0]             wr_data,
    input logic                          done,
    input logic                          keep_run,
    input logic                          grant_vld,
    input logic [CH_W-1:0]               grant_ch,
    input logic [NUM_CH-1:0]             start_q,
    input logic [NUM_CH-1:0]             irq_q,
    input logic [NUM_CH-1:0]             elig,
    input logic [NUM_CH-1:0][PRIO_W-1:0] prio_q
);
    // R7: grant holds until completion
    assert_grant_hold_R7: assert property (@(posedge clk) disable iff (rst)
        grant_vld && !done |=> grant_vld && $stable(grant_ch));

    // R4: an idle scheduler with an eligible channel grants next edge
    assert_grant_take_R4: assert property (@(posedge clk) disable iff (rst)
        !grant_vld && (elig != '0) |=> grant_vld);

    // R5: a new grant never lands on a zero-priority channel
    assert_no_zero_prio_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(grant_vld) && !$past(wr_en) |-> prio_q[grant_ch] != '0);

    // R8: completion raises the interrupt flag
    assert_done_irq_R8: assert property (@(posedge clk) disable iff (rst)
        grant_vld && done |=> irq_q[$past(grant_ch)]);

    // R8: completion without keep_run drops the start bit
    assert_done_stop_R8: assert property (@(posedge clk) disable iff (rst)
        grant_vld && done && !keep_run && !(wr_en && addr == OFS_START)
        |=> !start_q[$past(grant_ch)]);

    // R1: start writes set every requested bit
    assert_start_set_R1: assert property (@(posedge clk) disable iff (rst)
        wr_en && addr == OFS_START
        |=> (start_q & $past(wr_data[NUM_CH-1:0])) == $past(wr_data[NUM_CH-1:0]));

    // R2: stop writes clear every requested bit
    assert_stop_clr_R2: assert property (@(posedge clk) disable iff (rst)
        wr_en && addr == OFS_STOP
        |=> (start_q & $past(wr_data[NUM_CH-1:0])) == '0);

endmodule

bind dma_chan_sched dma_sched_chk #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_chk (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .done(done), .keep_run(keep_run), .grant_vld(grant_vld),
    .grant_ch(grant_ch), .start_q(start_q), .irq_q(irq_q), .elig(elig),
    .prio_q(prio_q)
);

// File: tb/dma_chan_sched_bench.sv
`timescale 1ns/1ps
module dma_chan_sched_bench;
    import dma_sched_pkg::*;

    localparam int NUM_CH  = 32;
    localparam int NUM_EVT = 48;
    localparam int CH_W    = 5;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               wr_en = 1'b0;
    logic [ADDR_W-1:0]  addr = '0;
    logic [DATA_W-1:0]  wr_data = '0;
    logic [DATA_W-1:0]  rd_data;
    logic [NUM_EVT-1:0] evt_req = '0;
    logic [NUM_CH-1:0]  dsp_ready = '0;
    logic               done = 1'b0;
    logic               keep_run = 1'b0;
    logic               grant_vld;
    logic [CH_W-1:0]    grant_ch;
    logic [NUM_CH-1:0]  irq_status;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    dma_chan_sched #(.NUM_CH(NUM_CH), .NUM_EVT(NUM_EVT)) u_dma_chan_sched (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
        .rd_data(rd_data), .evt_req(evt_req), .dsp_ready(dsp_ready),
        .done(done), .keep_run(keep_run), .grant_vld(grant_vld),
        .grant_ch(grant_ch), .irq_status(irq_status)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            fails++;
            $display("FAIL watchdog: actual %0d cycles, expected completion", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        wr_en = 1'b1; addr = a; wr_data = d;
        step();
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic rd_chk(input string req, input logic [ADDR_W-1:0] a, input logic [31:0] exp);
        addr = a;
        #1;
        check(req, rd_data, exp);
    endtask

    task automatic grant_chk(input string req, input logic v, input int ch);
        check(req, {31'b0, grant_vld}, {31'b0, v});
        if (v) check(req, {27'b0, grant_ch}, 32'(ch));
    endtask

    task automatic finish_ch(input logic keep);
        done = 1'b1; keep_run = keep;
        step();
        done = 1'b0; keep_run = 1'b0;
    endtask

    task automatic t_reset();
        grant_chk("R10", 1'b0, 0);
        rd_chk("R10", OFS_START, 0);
        rd_chk("R10", OFS_IRQ, 0);
        rd_chk("R10", OFS_PEND, 0);
        rd_chk("R10", OFS_PRIO + 12'd4, 0);
        rd_chk("R10", OFS_EMAP, 0);
    endtask

    task automatic t_start_stop();
        wr(OFS_START, 32'h0000_00F0);
        wr(OFS_START, 32'h0000_0003);
        rd_chk("R1", OFS_START, 32'h0000_00F3);
        wr(OFS_STOP, 32'h0000_0030);
        rd_chk("R2", OFS_STOP, 32'h0000_00C3);
        wr(OFS_STOP, 32'hFFFF_FFFF);
        rd_chk("R2", OFS_START, 0);
        grant_chk("R5", 1'b0, 0);
    endtask

    task automatic t_prio_width();
        wr(OFS_PRIO + 12'd20, 32'h0000_00FF);
        rd_chk("R11", OFS_PRIO + 12'd20, 32'd7);
        wr(OFS_PRIO + 12'd20, 0);
    endtask

    task automatic t_events();
        wr(OFS_EMAP + 12'd12, 32'h0000_0050);
        wr(OFS_EMAP + 12'd188, 32'h0000_0200);
        wr(OFS_EMAP + 12'd200, 32'hFFFF_FFFF);
        rd_chk("R12", OFS_EMAP + 12'd200, 0);
        evt_req[3] = 1'b1; evt_req[47] = 1'b1;
        step();
        evt_req = '0;
        rd_chk("R3", OFS_PEND, 32'h0000_0250);
        evt_req[0] = 1'b1;
        step();
        evt_req = '0;
        rd_chk("R3", OFS_PEND, 32'h0000_0250);
    endtask

    task automatic t_grant_flow();
        wr(OFS_DOVR, 32'hFFFF_FFFF);
        wr(OFS_PRIO + 12'd16, 32'd2);
        wr(OFS_PRIO + 12'd24, 32'd5);
        wr(OFS_START, 32'h0000_0050);
        step();
        grant_chk("R6", 1'b1, 6);
        rd_chk("R7", OFS_PEND, 32'h0000_0210);
        step(); step(); step();
        grant_chk("R7", 1'b1, 6);
        finish_ch(1'b0);
        grant_chk("R7", 1'b0, 0);
        rd_chk("R8", OFS_IRQ, 32'h0000_0040);
        rd_chk("R8", OFS_START, 32'h0000_0010);
        step();
        grant_chk("R7", 1'b1, 4);
        rd_chk("R7", OFS_PEND, 32'h0000_0200);
        finish_ch(1'b1);
        rd_chk("R8", OFS_START, 32'h0000_0010);
        rd_chk("R8", OFS_IRQ, 32'h0000_0050);
        step();
        grant_chk("R4", 1'b0, 0);
        wr(OFS_IRQ, 32'h0000_0040);
        rd_chk("R9", OFS_IRQ, 32'h0000_0010);
        wr(OFS_STOP, 32'hFFFF_FFFF);
        wr(OFS_IRQ, 32'hFFFF_FFFF);
        wr(OFS_PRIO + 12'd16, 0);
        wr(OFS_PRIO + 12'd24, 0);
    endtask

    task automatic t_zero_prio();
        wr(OFS_EOVR, 32'h0000_000C);
        wr(OFS_PRIO + 12'd12, 32'd1);
        wr(OFS_START, 32'h0000_0004);
        step(); step();
        grant_chk("R5", 1'b0, 0);
        wr(OFS_START, 32'h0000_0008);
        step();
        grant_chk("R4", 1'b1, 3);
        finish_ch(1'b0);
        rd_chk("R8", OFS_START, 32'h0000_0004);
        step(); step();
        grant_chk("R5", 1'b0, 0);
        wr(OFS_STOP, 32'hFFFF_FFFF);
        wr(OFS_EOVR, 0);
        wr(OFS_PRIO + 12'd12, 0);
        wr(OFS_IRQ, 32'hFFFF_FFFF);
    endtask

    task automatic t_tie();
        wr(OFS_PRIO + 12'd40, 32'd4);
        wr(OFS_PRIO + 12'd44, 32'd3);
        wr(OFS_PRIO + 12'd48, 32'd4);
        wr(OFS_EOVR, 32'h0000_1C00);
        wr(OFS_START, 32'h0000_1C00);
        step();
        grant_chk("R6", 1'b1, 10);
        finish_ch(1'b0);
        step();
        grant_chk("R6", 1'b1, 12);
        finish_ch(1'b0);
        step();
        grant_chk("R6", 1'b1, 11);
        finish_ch(1'b0);
        rd_chk("R8", OFS_START, 0);
        rd_chk("R8", OFS_IRQ, 32'h0000_1C00);
        wr(OFS_IRQ, 32'hFFFF_FFFF);
        wr(OFS_EOVR, 0);
        wr(OFS_PRIO + 12'd40, 0);
        wr(OFS_PRIO + 12'd44, 0);
        wr(OFS_PRIO + 12'd48, 0);
    endtask

    task automatic t_dsp_gate();
        wr(OFS_DOVR, 32'hFFEF_FFFF);
        wr(OFS_PRIO + 12'd80, 32'd1);
        wr(OFS_EOVR, 32'h0010_0000);
        wr(OFS_START, 32'h0010_0000);
        step(); step();
        grant_chk("R4", 1'b0, 0);
        dsp_ready[20] = 1'b1;
        step();
        grant_chk("R4", 1'b1, 20);
        wr_en = 1'b1; addr = OFS_IRQ; wr_data = 32'h0010_0000;
        done = 1'b1;
        step();
        wr_en = 1'b0; wr_data = '0; done = 1'b0;
        dsp_ready = '0;
        rd_chk("R9", OFS_IRQ, 32'h0010_0000);
        check("R9", irq_status, 32'h0010_0000);
        wr(OFS_IRQ, 32'hFFFF_FFFF);
        rd_chk("R9", OFS_IRQ, 0);
        wr(OFS_EOVR, 0);
        wr(OFS_PRIO + 12'd80, 0);
    endtask

    task automatic t_host_ovr();
        wr(OFS_PRIO + 12'd84, 32'd2);
        wr(OFS_EOVR, 32'h0020_0000);
        wr(OFS_HOVR, 32'h0020_0000);
        rd_chk("R4", OFS_START, 0);
        step();
        grant_chk("R4", 1'b1, 21);
        wr(OFS_HOVR, 0);
        finish_ch(1'b0);
        step(); step();
        grant_chk("R4", 1'b0, 0);
        check("R8", irq_status, 32'h0020_0000);
    endtask

    initial begin
        step(); step();
        rst = 1'b0;
        step();
        t_reset();
        t_start_stop();
        t_prio_width();
        t_events();
        t_grant_flow();
        t_zero_prio();
        t_tie();
        t_dsp_gate();
        t_host_ovr();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule